// File: doc/BRIEF.md
# CAN Receive Double-Buffer Manager

This block sits between the frame receiver of a CAN channel and the processor that drains it. When the receiver finishes a frame it presents the frame together with the verdict of the acceptance filter. Only frames the filter accepts are queued, into one of two storage entries. The oldest queued frame is always presented on the read side, together with the filter group index it matched. Software consumes it with a one-cycle release pulse, which frees that entry and moves the younger frame to the front.

An accepted frame can arrive while both entries are occupied and no release happens in the same cycle. In that case the frame is discarded, the two stored frames stay as they are, and a sticky overrun flag is raised. The flag can drive an interrupt line that has its own enable. A frame the filter rejects never changes the queue or the flag, whatever the fill level, so a full buffer cannot stop later frames from being received.

A second interrupt line is high while anything is waiting. A soft reset empties the queue and clears the overrun flag in one cycle.

Top module: `can_rx_dual_buffer`

## Requirements
- R1: During and after `rst` (synchronous, active high), `fill_cnt` is 0, `head_valid` is 0, `overrun` is 0, and both interrupt outputs are 0.
- R2: An accepted frame (`rx_valid`=1, `rx_accept`=1) that arrives at an empty buffer appears on the head outputs on the clock edge that samples it. The head outputs show its identifier, length code, payload and group index, and `fill_cnt` becomes 1.
- R3: A rejected frame (`rx_valid`=1, `rx_accept`=0) leaves `fill_cnt`, the head outputs and `overrun` unchanged at every fill level, including when both entries are full.
- R4: Frames are presented oldest first. A `rd_release` pulse while `fill_cnt`>0 removes the head frame, and the next edge shows the younger frame on the head outputs.
- R5: `rd_release` while the buffer is empty has no effect: `fill_cnt` stays 0 and no later frame is lost.
- R6: An accepted frame that arrives while `fill_cnt`=2 with no `rd_release` in that cycle sets `overrun`. The frame is dropped, and both stored frames and their order stay unchanged.
- R7: An accepted frame together with `rd_release` while `fill_cnt`=2 is queued behind the remaining frame. `overrun` does not change and `fill_cnt` stays 2.
- R8: `overrun` stays set until an `ovr_clear` pulse. If a new overrun event and `ovr_clear` fall in the same cycle, the flag stays set.
- R9: `ovr_irq` equals `overrun` AND `ovr_irq_en` at all times.
- R10: `rx_irq` is high exactly when `fill_cnt` is non-zero.
- R11: `soft_rst` empties the buffer and clears `overrun` on the next edge. It takes priority over an arrival, a release or an overrun in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Controller soft reset, clears queue and overrun |
| rx_valid | input | 1 | Receiver presents a completed frame this cycle |
| rx_accept | input | 1 | Acceptance filter verdict for the presented frame |
| rx_group | input | GRP_W (4) | Filter group index matched by the frame |
| rx_id | input | ID_W (29) | Frame identifier |
| rx_dlc | input | DLC_W (4) | Data length code |
| rx_data | input | DATA_W (64) | Frame payload |
| rd_release | input | 1 | Release the oldest stored frame |
| ovr_clear | input | 1 | Clear the overrun flag |
| ovr_irq_en | input | 1 | Enable for the overrun interrupt |
| head_valid | output | 1 | A frame is presented on the head outputs |
| head_group | output | GRP_W (4) | Group index of the oldest frame (0 when empty) |
| head_id | output | ID_W (29) | Identifier of the oldest frame (0 when empty) |
| head_dlc | output | DLC_W (4) | Length code of the oldest frame (0 when empty) |
| head_data | output | DATA_W (64) | Payload of the oldest frame (0 when empty) |
| fill_cnt | output | CNT_W (2) | Number of stored frames, 0 to 2 |
| overrun | output | 1 | Sticky data-overrun status |
| rx_irq | output | 1 | Receive interrupt, frames waiting |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The table-driven sequence interleaves accepted and rejected frames at each fill level. A rejected frame at fill 2 is checked apart from an accepted one at fill 2, which separates the lock-free discard from a true overrun. Each frame carries a distinct identifier, payload and group, so after releases the head outputs show whether the dropped frame was really dropped and whether the order was kept. Directed cases cover the collisions: a release together with an arrival at full, a clear together with a fresh overrun, a soft reset together with traffic, and the overrun interrupt with its enable off.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
    parameter int unsigned ID_W      = 29;
    parameter int unsigned DLC_W     = 4;
    parameter int unsigned DATA_W    = 64;
    parameter int unsigned GRP_W     = 4;
    parameter int unsigned RXQ_DEPTH = 2;

    localparam int unsigned PTR_W = (RXQ_DEPTH > 1) ? $clog2(RXQ_DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(RXQ_DEPTH + 1);

    typedef struct packed {
        logic [GRP_W-1:0]  grp;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    // Reduce a slot index sum back into the range 0..RXQ_DEPTH-1.
    function automatic logic [PTR_W-1:0] ptr_wrap(input logic [PTR_W:0] raw);
        if (raw >= (PTR_W+1)'(RXQ_DEPTH))
            return PTR_W'(raw - (PTR_W+1)'(RXQ_DEPTH));
        else
            return PTR_W'(raw);
    endfunction
endpackage

// File: rtl/rxq_slot.sv
module rxq_slot
    import can_rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  rx_frame_t din,
    output rx_frame_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= din;
    end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import can_rxq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 acc,
    input  logic                 rel_req,
    input  logic                 ovr_clear,
    output logic [PTR_W-1:0]     head_ptr,
    output logic [CNT_W-1:0]     count,
    output logic                 ovr_flag,
    output logic [RXQ_DEPTH-1:0] wr_en
);
    logic             rel;
    logic             full;
    logic             store;
    logic             ovr_evt;
    logic [PTR_W-1:0] wr_ptr;

    always_comb begin
        rel     = rel_req && (count != '0);
        full    = (count == CNT_W'(RXQ_DEPTH));
        // A release in the same cycle frees the head slot for the arrival.
        store   = acc && (!full || rel);
        ovr_evt = acc && full && !rel;
        wr_ptr  = ptr_wrap({1'b0, head_ptr} + (PTR_W+1)'(count));
        wr_en   = '0;
        if (store)
            wr_en[wr_ptr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            head_ptr <= '0;
            count    <= '0;
            ovr_flag <= 1'b0;
        end else begin
            if (rel)
                head_ptr <= ptr_wrap({1'b0, head_ptr} + (PTR_W+1)'(1));
            count <= count + CNT_W'(store) - CNT_W'(rel);
            if (ovr_evt)
                ovr_flag <= 1'b1;
            else if (ovr_clear)
                ovr_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
    input  logic pending,
    input  logic ovr_flag,
    input  logic ovr_en,
    output logic rx_irq,
    output logic ovr_irq
);
    always_comb begin
        rx_irq  = pending;
        ovr_irq = ovr_flag && ovr_en;
    end
endmodule

// File: rtl/can_rx_dual_buffer.sv
module can_rx_dual_buffer
    import can_rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              rx_valid,
    input  logic              rx_accept,
    input  logic [GRP_W-1:0]  rx_group,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rd_release,
    input  logic              ovr_clear,
    input  logic              ovr_irq_en,
    output logic              head_valid,
    output logic [GRP_W-1:0]  head_group,
    output logic [ID_W-1:0]   head_id,
    output logic [DLC_W-1:0]  head_dlc,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic              overrun,
    output logic              rx_irq,
    output logic              ovr_irq
);
    rx_frame_t              in_frame;
    rx_frame_t              slot_q [RXQ_DEPTH];
    rx_frame_t              head_frame;
    logic [RXQ_DEPTH-1:0]   wr_en;
    logic [PTR_W-1:0]       head_ptr;
    logic                   ovr_flag;
    logic [CNT_W-1:0]       count;

    always_comb begin
        in_frame.grp  = rx_group;
        in_frame.id   = rx_id;
        in_frame.dlc  = rx_dlc;
        in_frame.data = rx_data;
    end

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .acc      (rx_valid && rx_accept),
        .rel_req  (rd_release),
        .ovr_clear(ovr_clear),
        .head_ptr (head_ptr),
        .count    (count),
        .ovr_flag (ovr_flag),
        .wr_en    (wr_en)
    );

    for (genvar g = 0; g < RXQ_DEPTH; g++) begin : g_slot
        rxq_slot u_slot (
            .clk (clk),
            .rst (rst),
            .we  (wr_en[g]),
            .din (in_frame),
            .q   (slot_q[g])
        );
    end

    always_comb begin
        head_valid = (count != '0);
        head_frame = head_valid ? slot_q[head_ptr] : '0;
        head_group = head_frame.grp;
        head_id    = head_frame.id;
        head_dlc   = head_frame.dlc;
        head_data  = head_frame.data;
        fill_cnt   = count;
        overrun    = ovr_flag;
    end

    rxq_irq u_irq (
        .pending (head_valid),
        .ovr_flag(ovr_flag),
        .ovr_en  (ovr_irq_en),
        .rx_irq  (rx_irq),
        .ovr_irq (ovr_irq)
    );
endmodule

// File: rtl/can_rxq_checker.sv
module can_rxq_checker
    import can_rxq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              rx_valid,
    input logic              rx_accept,
    input logic              rd_release,
    input logic              ovr_clear,
    input logic              ovr_irq_en,
    input logic              head_valid,
    input logic [ID_W-1:0]   head_id,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic              overrun,
    input logic              rx_irq,
    input logic              ovr_irq
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(RXQ_DEPTH);

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (fill_cnt == '0) && !overrun && !head_valid);

    assert_reject_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_accept && !rd_release && !ovr_clear && !soft_rst)
        |=> (fill_cnt == $past(fill_cnt)) && (overrun == $past(overrun))
            && (head_id == $past(head_id)));

    assert_overrun_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == FULL && rx_valid && rx_accept && !rd_release && !soft_rst)
        |=> overrun && (fill_cnt == FULL) && (head_id == $past(head_id)));

    assert_empty_release_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == '0 && rd_release && !rx_valid && !soft_rst)
        |=> (fill_cnt == '0));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clear && !soft_rst) |=> overrun);

    assert_ovr_irq_R9: assert property (@(posedge clk) disable iff (rst)
        ovr_irq == (overrun && ovr_irq_en));

    assert_rx_irq_R10: assert property (@(posedge clk) disable iff (rst)
        rx_irq == (fill_cnt != '0));

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= FULL);
endmodule

bind can_rx_dual_buffer can_rxq_checker u_rxq_checker (.*);

// File: tb/test_can_rx_dual_buffer.sv
module test_can_rx_dual_buffer;
    import can_rxq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              soft_rst = 1'b0;
    logic              rx_valid = 1'b0;
    logic              rx_accept = 1'b0;
    logic [GRP_W-1:0]  rx_group = '0;
    logic [ID_W-1:0]   rx_id = '0;
    logic [DLC_W-1:0]  rx_dlc = '0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rd_release = 1'b0;
    logic              ovr_clear = 1'b0;
    logic              ovr_irq_en = 1'b1;
    logic              head_valid;
    logic [GRP_W-1:0]  head_group;
    logic [ID_W-1:0]   head_id;
    logic [DLC_W-1:0]  head_dlc;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  fill_cnt;
    logic              overrun;
    logic              rx_irq;
    logic              ovr_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    can_rx_dual_buffer i_can_rx_dual_buffer (.*);

    // {valid, accept, release, clear, id, exp_fill, exp_ovr, exp_hv, exp_head}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {4'b1100, 8'h11, 2'd1, 1'b0, 1'b1, 8'h11},  // R2 first frame
        {4'b1000, 8'h22, 2'd1, 1'b0, 1'b1, 8'h11},  // R3 reject at fill 1
        {4'b1100, 8'h33, 2'd2, 1'b0, 1'b1, 8'h11},  // R4 second queued behind
        {4'b1000, 8'h44, 2'd2, 1'b0, 1'b1, 8'h11},  // R3 reject while full
        {4'b1100, 8'h55, 2'd2, 1'b1, 1'b1, 8'h11},  // R6 overrun, frame dropped
        {4'b0010, 8'h00, 2'd1, 1'b1, 1'b1, 8'h33},  // R4 younger promoted
        {4'b0010, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00},  // R10 empty again
        {4'b0010, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00},  // R5 release on empty
        {4'b0001, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00},  // R8 clear
        {4'b1100, 8'h66, 2'd1, 1'b0, 1'b1, 8'h66},  // R5 nothing lost after
        {4'b1100, 8'h77, 2'd2, 1'b0, 1'b1, 8'h66},
        {4'b1110, 8'h88, 2'd2, 1'b0, 1'b1, 8'h77},  // R7 release + arrival
        {4'b0010, 8'h00, 2'd1, 1'b0, 1'b1, 8'h88},  // R4
        {4'b0010, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic a, input logic rel,
                         input logic clr, input logic [7:0] id);
        rx_valid   = v;
        rx_accept  = a;
        rd_release = rel;
        ovr_clear  = clr;
        rx_id      = ID_W'(id);
        rx_dlc     = id[7:4];
        rx_group   = id[3:0];
        rx_data    = {8{id}};
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        soft_rst = 1'b0;
    endtask

    // Packs all observable state; expected head fields follow the id encoding.
    function automatic logic [127:0] obs_pack();
        return {head_data[31:0], head_group, head_dlc, head_id[7:0], fill_cnt,
                overrun, head_valid, rx_irq, ovr_irq};
    endfunction

    function automatic logic [127:0] exp_pack(input logic [1:0] f, input logic o,
                                               input logic hv, input logic [7:0] h,
                                               input logic en);
        return {{4{h}}, h[3:0], h[7:4], h, f, o, hv, (f != 2'd0), o & en};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h99);
        repeat (2) @(negedge clk);
        check("R1 in reset", obs_pack(), exp_pack(2'd0, 1'b0, 1'b0, 8'h00, 1'b1));
        idle();
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", obs_pack(), exp_pack(2'd0, 1'b0, 1'b0, 8'h00, 1'b1));

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
            @(negedge clk);
            check($sformatf("vector %0d (R2..R10)", i), obs_pack(),
                  exp_pack(VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b1));
        end
        idle();

        // R8: clear collides with new overrun, flag stays set
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'hA1); @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'hB2); @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'hC3); @(negedge clk);
        check("R8 set beats clear", obs_pack(), exp_pack(2'd2, 1'b1, 1'b1, 8'hA1, 1'b1));
        idle(); @(negedge clk);
        check("R8 sticky", obs_pack(), exp_pack(2'd2, 1'b1, 1'b1, 8'hA1, 1'b1));

        // R9: overrun interrupt masked
        ovr_irq_en = 1'b0; #1;
        check("R9 irq masked", obs_pack(), exp_pack(2'd2, 1'b1, 1'b1, 8'hA1, 1'b0));
        ovr_irq_en = 1'b1; #1;
        check("R9 irq enabled", {127'd0, ovr_irq}, 128'd1);

        // R3: rejected frame while full and overrun set changes nothing
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hD4); @(negedge clk);
        check("R3 reject full+ovr", obs_pack(), exp_pack(2'd2, 1'b1, 1'b1, 8'hA1, 1'b1));
        idle();

        // R11: soft reset beats arrival and release
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hE5);
        soft_rst = 1'b1;
        @(negedge clk);
        check("R11 soft reset", obs_pack(), exp_pack(2'd0, 1'b0, 1'b0, 8'h00, 1'b1));
        idle();

        // R2 after soft reset: reception still works
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h5A); @(negedge clk);
        check("R2 after soft reset", obs_pack(), exp_pack(2'd1, 1'b0, 1'b1, 8'h5A, 1'b1));
        idle(); @(negedge clk);

        // R1: hard reset clears a filled buffer
        rst = 1'b1; @(negedge clk);
        rst = 1'b0; @(negedge clk);
        check("R1 reset clears", obs_pack(), exp_pack(2'd0, 1'b0, 1'b0, 8'h00, 1'b1));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule